// File: doc/BRIEF.md
# Nibble Serial Port with Accumulator Swap

This block is the serial port register of a small 4-bit processor core. A single nibble register does one of two jobs. In shift mode it is a serial-in, serial-out shift register stepped by the instruction-cycle tick. In counter mode it is a binary event counter that advances on each rising edge of the serial input. A mode bit selects the job. The processor reaches the register in only one way: an exchange strobe. In one cycle the exchange places the register's old contents on the accumulator-facing output and loads the accumulator value into the register.

The exchange also loads the serial clock output register from a dedicated control bit. While shift mode is active and that bit is set, the serial clock toggles once per tick. Software keeps an unbroken serial stream by exchanging once every four ticks. Each exchange hands out the four received bits and puts in the next four to send.

Top module: `sio_xchg`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the register to 0 and the serial clock output to 0. After reset the serial data output is 0.
- R2: With xchg high at a clock edge, the register takes acc_in. In that same cycle, acc_out shows the register's value from before the exchange.
- R3: The exchange has priority. When xchg is high, a shift tick or a counter edge in the same cycle has no effect on the loaded value.
- R4: In shift mode (cnt_mode = 0), at each clock edge with tick high and xchg low, the register shifts one place toward bit 3 and si enters bit 0.
- R5: In shift mode, so equals register bit 3. In counter mode (cnt_mode = 1), so is 0.
- R6: In shift mode, the register holds its value at any edge where both tick and xchg are low.
- R7: In counter mode, si passes through two synchroniser flops. The register increments by one for each 0-to-1 transition of si. The new count appears after the third clock edge following the rise. A steady or falling si does not change the count.
- R8: In counter mode, the count wraps from 15 to 0.
- R9: An exchange loads the serial clock output sk from sclk_en. sk shows the new value after that edge.
- R10: After an exchange with sclk_en = 1, sk inverts at each edge where tick is high, xchg is low and the block is in shift mode. sk holds at all other edges without an exchange, and always holds when the loaded control bit is 0.
- R11: In shift mode, an exchange followed by four ticks sends the loaded nibble on so, most significant bit first. The same sequence receives four si bits, the first received ending in bit 3, so the next exchange returns the received nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Instruction-cycle tick, one clock wide |
| cnt_mode | input | 1 | 0 = shift register, 1 = event counter |
| xchg | input | 1 | Exchange strobe |
| acc_in | input | W | Accumulator value to load |
| sclk_en | input | 1 | Serial clock control bit loaded by an exchange |
| si | input | 1 | Serial data in / count event input |
| acc_out | output | W | Register contents returned to the accumulator |
| so | output | 1 | Serial data out |
| sk | output | 1 | Serial clock output |

## Verification
A wrong register value appears at so within one tick in shift mode. It always appears on acc_out at the next exchange, because acc_out shows the register continuously. Synchroniser or edge-detect faults show up as a count that is early, late, doubled or missing. Because the expected count is sampled at exactly the third edge after the si rise, any of these is visible within four cycles. A wrong serial clock control state shows up as an sk value that misses a toggle, or toggles when it should hold, on the first tick after the exchange.

// File: rtl/sio_xchg.sv
module sio_xchg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_mode,
  input  logic         xchg,
  input  logic [W-1:0] acc_in,
  input  logic         sclk_en,
  input  logic         si,
  output logic [W-1:0] acc_out,
  output logic         so,
  output logic         sk
);
  logic [W-1:0] sreg;
  logic [2:0]   sync;
  logic         sk_q, sk_ctl;
  logic         step, rise;

  assign step = tick & ~cnt_mode;
  assign rise = cnt_mode & sync[1] & ~sync[2];

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[1:0], si};
  end

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (xchg) sreg <= acc_in;
    else if (step) sreg <= {sreg[W-2:0], si};
    else if (rise) sreg <= sreg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q   <= 1'b0;
      sk_ctl <= 1'b0;
    end else if (xchg) begin
      sk_q   <= sclk_en;
      sk_ctl <= sclk_en;
    end else if (step && sk_ctl) begin
      sk_q   <= ~sk_q;
    end
  end

  assign acc_out = sreg;
  assign so      = ~cnt_mode & sreg[W-1];
  assign sk      = sk_q;
endmodule

module sio_xchg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cnt_mode,
  input logic         xchg,
  input logic [W-1:0] acc_in,
  input logic         sclk_en,
  input logic         si,
  input logic [W-1:0] acc_out,
  input logic         so,
  input logic         sk
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !sk));

  assert_xchg_load_R2: assert property (@(posedge clk) disable iff (rst)
    xchg |=> acc_out == $past(acc_in));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!xchg && tick && !cnt_mode) |=> acc_out == {$past(acc_out[W-2:0]), $past(si)});

  assert_so_mode_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_mode |-> !so);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!xchg && !tick && !cnt_mode) |=> $stable(acc_out));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!xchg && cnt_mode) |=> (acc_out == $past(acc_out) || acc_out == W'($past(acc_out) + 1'b1)));

  assert_sk_load_R9: assert property (@(posedge clk) disable iff (rst)
    xchg |=> sk == $past(sclk_en));

  assert_sk_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!xchg && !(tick && !cnt_mode)) |=> $stable(sk));
endmodule

bind sio_xchg sio_xchg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_mode(cnt_mode), .xchg(xchg),
  .acc_in(acc_in), .sclk_en(sclk_en), .si(si), .acc_out(acc_out),
  .so(so), .sk(sk)
);

// File: tb/sio_xchg_bench.sv
module sio_xchg_bench;
  logic clk = 0, rst = 1, tick = 0, cnt_mode = 0, xchg = 0, sclk_en = 0, si = 0;
  logic [3:0] acc_in = '0;
  logic [3:0] acc_out;
  logic so, sk;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_xchg #(.W(4)) u_sio_xchg (
    .clk(clk), .rst(rst), .tick(tick), .cnt_mode(cnt_mode), .xchg(xchg),
    .acc_in(acc_in), .sclk_en(sclk_en), .si(si), .acc_out(acc_out),
    .so(so), .sk(sk));

  // {load value, si nibble (first bit = msb), expected so stream, expected received}
  localparam logic [15:0] VEC [6] = '{
    16'hA5A5, 16'h3C3C, 16'hF0F0, 16'h0F0F, 16'h9696, 16'h6161};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xload(logic [3:0] v, logic en);
    xchg = 1; acc_in = v; sclk_en = en; step(); xchg = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    #1; step(); step(); rst = 0;
    check(acc_out == 0, "R1", acc_out, 0);
    check(sk == 0, "R1", sk, 0);
    check(so == 0, "R1", so, 0);

    foreach (VEC[k]) begin
      logic [3:0] ld, sn, es, er;
      {ld, sn, es, er} = VEC[k];
      xload(ld, 0);
      check(acc_out == ld, "R2", acc_out, ld);
      for (int i = 3; i >= 0; i--) begin
        check(so == es[i], "R5", so, es[i]);
        tick = 1; si = sn[i]; step();
      end
      tick = 0; si = 0;
      check(acc_out == er, "R11", acc_out, er);
    end

    // R2: old value visible during the exchange cycle
    xchg = 1; acc_in = 4'h3; #1;
    check(acc_out == 4'h1, "R2", acc_out, 1);
    step(); xchg = 0;
    check(acc_out == 4'h3, "R2", acc_out, 3);

    // R4: single shift
    tick = 1; si = 1; step(); tick = 0; si = 0;
    check(acc_out == 4'h7, "R4", acc_out, 7);

    // R6: hold without tick
    si = 1; step(); step(); step(); si = 0;
    check(acc_out == 4'h7, "R6", acc_out, 7);

    // R3: exchange beats shift
    xchg = 1; acc_in = 4'h8; tick = 1; si = 1; step();
    xchg = 0; tick = 0; si = 0;
    check(acc_out == 4'h8, "R3", acc_out, 8);

    // R9/R10: serial clock
    xload(4'h0, 1);
    check(sk == 1, "R9", sk, 1);
    tick = 1; step();
    check(sk == 0, "R10", sk, 0);
    step();
    check(sk == 1, "R10", sk, 1);
    tick = 0; step();
    check(sk == 1, "R10", sk, 1);
    cnt_mode = 1; tick = 1; step(); step(); tick = 0;
    check(sk == 1, "R10", sk, 1);
    cnt_mode = 0;
    xload(4'h0, 0);
    check(sk == 0, "R9", sk, 0);
    tick = 1; step(); step(); tick = 0;
    check(sk == 0, "R10", sk, 0);

    // R7/R8: counter
    cnt_mode = 1; si = 0; step(); step(); step();
    xload(4'he, 0);
    check(so == 0, "R5", so, 0);
    si = 1; step(); step();
    check(acc_out == 4'he, "R7", acc_out, 14);
    step();
    check(acc_out == 4'hf, "R7", acc_out, 15);
    step(); step();
    check(acc_out == 4'hf, "R7", acc_out, 15);
    si = 0; step(); step(); step(); step();
    check(acc_out == 4'hf, "R7", acc_out, 15);
    si = 1; step(); step(); step();
    check(acc_out == 4'h0, "R8", acc_out, 0);
    step(); step(); step();
    check(acc_out == 4'h0, "R7", acc_out, 0);

    // R3: exchange beats counter edge
    si = 0; step(); step(); step();
    si = 1; step(); step();
    xchg = 1; acc_in = 4'h5; step(); xchg = 0;
    check(acc_out == 4'h5, "R3", acc_out, 5);
    step(); step();
    check(acc_out == 4'h5, "R3", acc_out, 5);

    // R1: reset mid-run
    xload(4'hb, 1);
    rst = 1; step(); rst = 0;
    check(acc_out == 0, "R1", acc_out, 0);
    check(sk == 0, "R1", sk, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule